// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Lines

A countdown watchdog driven by a slow tick enable (nominally 32 kHz) and controlled through a small 32-bit register port. Every register write has to carry a fixed key pattern. A write without that pattern leaves all state unchanged. Software arms the timer with a timeout and enables it, and then has to keep writing the kick word to the restart register. If the kicks stop and the count runs out, the block drives a fixed-width system reset pulse. It can also raise an interrupt with that pulse, and it can drive an external reset pin at a polarity chosen by software.

The same register port gives two more reset controls. A keyed immediate software reset fires the system reset pulse whether or not the timer is enabled. A keyed domain register holds one reset line per subsystem, and each line stays asserted as long as its bit is set. The live counter value can be read back. Each timeout unit is `2**UNIT_LOG` ticks. With the default of 512 ticks per unit, 64 units make one second, and the reset default of 1984 units gives 31 seconds.

Top module: `wdg_keyed`

## Requirements
- R1: After reset the following hold: the control register reads 0, the length register reads 1984 in bits [15:5], the domain register reads 0, the counter reads `1984 * 2**UNIT_LOG`, `sys_rst` and `irq` are 0, `dom_rst` is 0 and `ext_rst` is 1.
- R2: A write to offset 0x00 is stored only when bits [31:24] are 0x22. The stored bits are: bit0 run, bit1 pin polarity (1 = active high), bit2 pin enable, bit3 interrupt enable, bit4 auto-start and bit6 dual. A read returns only these bits, with every other bit at 0.
- R3: A write to offset 0x04 is stored only when bits [4:0] are 0x08. The timeout field is bits [5 +: LEN_W]. A read returns the field in those bits and 0 everywhere else.
- R4: Writing exactly 0x00001971 to offset 0x08 reloads the counter to `field * 2**UNIT_LOG` at that edge. Any other value written there leaves the countdown unchanged.
- R5: Offset 0x0C reads the live counter. While run is set, the counter drops by one on every clock with `tick` high and holds its value when `tick` is low. While run is clear, it equals the reload value. A keyed write that sets run loads the reload value at that edge.
- R6: With run set and `tick` held high, `sys_rst` rises exactly `field * 2**UNIT_LOG` clocks after the arming edge. It then stays high for PULSE (16) clocks.
- R7: `irq` is high for the same clocks as a watchdog-expiry pulse when interrupt enable was set at expiry. Otherwise `irq` stays 0.
- R8: `ext_rst` equals the polarity bit while `sys_rst` is high and pin enable is set. At all other times it equals the inverse of the polarity bit.
- R9: Writing exactly 0x00001209 to offset 0x14 raises `sys_rst` from the next clock for PULSE clocks, whether or not run is set. It does not raise `irq`. Any other value written there has no effect.
- R10: A write to offset 0x18 loads bits [DOMAINS-1:0] into the domain register only when bits [31:24] are 0x88. Each bit drives the matching `dom_rst` line. A read returns the register.
- R11: A keyed write that clears run stops the countdown. No expiry pulse follows, and the counter returns to the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per slow-clock period |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, including the key field |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst | output | 1 | System reset pulse, active high |
| irq | output | 1 | Interrupt raised with a watchdog-expiry pulse |
| ext_rst | output | 1 | External reset pin at the programmed polarity |
| dom_rst | output | DOMAINS | Per-domain software reset lines |

## Verification
The properties assume that `bus_we` is a single-cycle strobe, with address and data stable at the sampling edge. They also assume that `tick` does not disturb register decoding. The count-hold property excludes cycles that carry a write to the control or restart register, because those writes legitimately move the counter. The bench drives every input on the falling edge and releases the strobe after one clock, so each write lands on exactly one rising edge. The bench also sets every timeout longer than the reset pulse, so a second expiry cannot stretch a pulse that is being measured.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   localparam logic [7:0] OFS_MODE  = 8'h00;
   localparam logic [7:0] OFS_LEN   = 8'h04;
   localparam logic [7:0] OFS_KICK  = 8'h08;
   localparam logic [7:0] OFS_CNT   = 8'h0C;
   localparam logic [7:0] OFS_SWRST = 8'h14;
   localparam logic [7:0] OFS_DOM   = 8'h18;

   localparam logic [7:0]  KEY_MODE   = 8'h22;
   localparam logic [7:0]  KEY_DOM    = 8'h88;
   localparam logic [4:0]  KEY_LEN    = 5'h08;
   localparam logic [31:0] KICK_WORD  = 32'h0000_1971;
   localparam logic [31:0] SWRST_WORD = 32'h0000_1209;
   localparam int          LEN_LSB    = 5;

   typedef struct packed {
      logic dual;
      logic auto_go;
      logic irq_on;
      logic xrst_on;
      logic xrst_hi;
      logic run;
   } wdg_mode_t;

   function automatic wdg_mode_t word_to_mode(logic [31:0] w);
      wdg_mode_t m;
      m.run     = w[0];
      m.xrst_hi = w[1];
      m.xrst_on = w[2];
      m.irq_on  = w[3];
      m.auto_go = w[4];
      m.dual    = w[6];
      return m;
   endfunction

   function automatic logic [31:0] mode_to_word(wdg_mode_t m);
      logic [31:0] w;
      w    = '0;
      w[0] = m.run;
      w[1] = m.xrst_hi;
      w[2] = m.xrst_on;
      w[3] = m.irq_on;
      w[4] = m.auto_go;
      w[6] = m.dual;
      return w;
   endfunction
endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int LEN_W   = 11,
   parameter int CNT_W   = 20,
   parameter int DOMAINS = 4,
   parameter int DEF_LEN = 1984
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [7:0]         addr,
   input  logic [31:0]        wdata,
   input  logic [CNT_W-1:0]   count_i,
   output wdg_mode_t          mode_o,
   output logic [LEN_W-1:0]   len_o,
   output logic [DOMAINS-1:0] dom_o,
   output logic               kick_o,
   output logic               swrst_o,
   output logic [31:0]        rdata_o
);
   logic hit_mode, hit_len, hit_dom;

   assign hit_mode = we && (addr == OFS_MODE) && (wdata[31:24] == KEY_MODE);
   assign hit_len  = we && (addr == OFS_LEN)  && (wdata[4:0]   == KEY_LEN);
   assign hit_dom  = we && (addr == OFS_DOM)  && (wdata[31:24] == KEY_DOM);
   assign kick_o   = we && (addr == OFS_KICK)  && (wdata == KICK_WORD);
   assign swrst_o  = we && (addr == OFS_SWRST) && (wdata == SWRST_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= '0;
      end else if (hit_mode) begin
         mode_o <= word_to_mode(wdata);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_o <= LEN_W'(DEF_LEN);
      end else if (hit_len) begin
         len_o <= wdata[LEN_LSB +: LEN_W];
      end
   end

   for (genvar g = 0; g < DOMAINS; g++) begin : g_dom
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dom_o[g] <= 1'b0;
         end else if (hit_dom) begin
            dom_o[g] <= wdata[g];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr)
         OFS_MODE: rdata_o = mode_to_word(mode_o);
         OFS_LEN:  rdata_o[LEN_LSB +: LEN_W] = len_o;
         OFS_CNT:  rdata_o[CNT_W-1:0] = count_i;
         OFS_DOM:  rdata_o[DOMAINS-1:0] = dom_o;
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/wdg_counter.sv
`timescale 1ns/1ps
module wdg_counter #(
   parameter int LEN_W    = 11,
   parameter int UNIT_LOG = 9,
   parameter int DEF_LEN  = 1984,
   localparam int CNT_W   = LEN_W + UNIT_LOG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             kick,
   input  logic [LEN_W-1:0] len,
   output logic [CNT_W-1:0] count_o,
   output logic             fire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [LEN_W-1:0] DEF = LEN_W'(DEF_LEN);

   logic [CNT_W-1:0] reload;
   logic             last;

   assign reload = {len, {UNIT_LOG{1'b0}}};
   assign last   = (count_o <= ONE);
   assign fire_o = run && !kick && tick && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= {DEF, {UNIT_LOG{1'b0}}};
      end else if (!run || kick) begin
         count_o <= reload;
      end else if (tick) begin
         count_o <= last ? reload : count_o - ONE;
      end
   end
endmodule

// File: rtl/wdg_pulse.sv
`timescale 1ns/1ps
module wdg_pulse #(
   parameter int PULSE       = 16,
   parameter bit EXT_OUT_REG = 1'b0,
   localparam int PW         = $clog2(PULSE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic swrst,
   input  logic irq_on,
   input  logic xrst_on,
   input  logic xrst_hi,
   output logic sys_rst_o,
   output logic irq_o,
   output logic ext_rst_o
);
   logic [PW-1:0] left_q;
   logic          load;
   logic          pin_lvl;

   assign load      = fire || swrst;
   assign sys_rst_o = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= PW'(PULSE);
      end else if (left_q != '0) begin
         left_q <= left_q - PW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else if (fire && irq_on) begin
         irq_o <= 1'b1;
      end else if (!load && (left_q <= PW'(1))) begin
         irq_o <= 1'b0;
      end
   end

   assign pin_lvl = (sys_rst_o && xrst_on) ? xrst_hi : !xrst_hi;

   if (EXT_OUT_REG) begin : g_pin_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ext_rst_o <= 1'b1;
         end else begin
            ext_rst_o <= pin_lvl;
         end
      end
   end else begin : g_pin_comb
      assign ext_rst_o = pin_lvl;
   end
endmodule

// File: rtl/wdg_keyed.sv
`timescale 1ns/1ps
module wdg_keyed
   import wdg_pkg::*;
#(
   parameter int LEN_W       = 11,
   parameter int UNIT_LOG    = 9,
   parameter int DOMAINS     = 4,
   parameter int PULSE       = 16,
   parameter int DEF_LEN     = 1984,
   parameter bit EXT_OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               bus_we,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               sys_rst,
   output logic               irq,
   output logic               ext_rst,
   output logic [DOMAINS-1:0] dom_rst
);
   localparam int CNT_W = LEN_W + UNIT_LOG;

   if (DOMAINS < 1 || DOMAINS > 24) begin : g_bad_domains
      $error("DOMAINS must lie in 1..24 so it stays below the key byte");
   end
   if (LEN_W < 1 || LEN_LSB + LEN_W > 32) begin : g_bad_len
      $error("LEN_W must fit above the length key field");
   end
   if (UNIT_LOG < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("UNIT_LOG must be at least 1 and the counter at most 32 bits");
   end
   if (PULSE < 1) begin : g_bad_pulse
      $error("PULSE must be at least 1");
   end
   if (DEF_LEN < 1 || DEF_LEN >= (1 << LEN_W)) begin : g_bad_def
      $error("DEF_LEN must fit the length field");
   end

   wdg_mode_t        mode_q;
   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] count;
   logic             kick, swrst, fire;

   wdg_regs #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .DOMAINS(DOMAINS), .DEF_LEN(DEF_LEN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .count_i(count), .mode_o(mode_q), .len_o(len_q),
      .dom_o(dom_rst), .kick_o(kick), .swrst_o(swrst), .rdata_o(bus_rdata)
   );

   wdg_counter #(
      .LEN_W(LEN_W), .UNIT_LOG(UNIT_LOG), .DEF_LEN(DEF_LEN)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(mode_q.run), .tick(tick), .kick(kick),
      .len(len_q), .count_o(count), .fire_o(fire)
   );

   wdg_pulse #(
      .PULSE(PULSE), .EXT_OUT_REG(EXT_OUT_REG)
   ) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .swrst(swrst),
      .irq_on(mode_q.irq_on), .xrst_on(mode_q.xrst_on),
      .xrst_hi(mode_q.xrst_hi), .sys_rst_o(sys_rst), .irq_o(irq),
      .ext_rst_o(ext_rst)
   );
endmodule

// File: rtl/wdg_keyed_chk.sv
`timescale 1ns/1ps
module wdg_keyed_chk
   import wdg_pkg::*;
#(
   parameter int LEN_W       = 11,
   parameter int CNT_W       = 20,
   parameter int DOMAINS     = 4,
   parameter bit EXT_OUT_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               bus_we,
   input logic [7:0]         bus_addr,
   input logic [31:0]        bus_wdata,
   input logic               sys_rst,
   input logic               irq,
   input logic               ext_rst,
   input logic [DOMAINS-1:0] dom_rst,
   input wdg_mode_t          mode_q,
   input logic [LEN_W-1:0]   len_q,
   input logic [CNT_W-1:0]   count
);
   logic swrst_wr, mode_or_kick_wr;
   assign swrst_wr = bus_we && bus_addr == OFS_SWRST && bus_wdata == SWRST_WORD;
   assign mode_or_kick_wr = bus_we && (bus_addr == OFS_MODE || bus_addr == OFS_KICK);

   assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_MODE && bus_wdata[31:24] != KEY_MODE) |=> $stable(mode_q));

   assert_len_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_LEN && bus_wdata[4:0] != KEY_LEN) |=> $stable(len_q));

   assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.run && !tick && !mode_or_kick_wr) |=> $stable(count));

   assert_irq_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> sys_rst);

   assert_swrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_wr |=> sys_rst);

   assert_dom_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DOM && bus_wdata[31:24] != KEY_DOM) |=> $stable(dom_rst));

   assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.run && !swrst_wr) |=> !$rose(sys_rst));

   if (!EXT_OUT_REG) begin : g_pin_chk
      assert_ext_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (sys_rst && mode_q.xrst_on) |-> (ext_rst == mode_q.xrst_hi));
   end
endmodule

bind wdg_keyed wdg_keyed_chk #(
   .LEN_W(LEN_W), .CNT_W(LEN_W + UNIT_LOG), .DOMAINS(DOMAINS), .EXT_OUT_REG(EXT_OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .sys_rst(sys_rst), .irq(irq), .ext_rst(ext_rst),
   .dom_rst(dom_rst), .mode_q(mode_q), .len_q(len_q), .count(count)
);

// File: tb/wdg_keyed_test.sv
`timescale 1ns/1ps
module wdg_keyed_test;
   localparam int DOMAINS  = 4;
   localparam int UNIT_LOG = 3;
   localparam int LEN_W    = 11;
   localparam int PULSE    = 16;
   localparam int DEF_LEN  = 1984;

   logic        clk = 1'b0;
   logic        rst_n, tick, bus_we;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        sys_rst, irq, ext_rst;
   logic [DOMAINS-1:0] dom_rst;
   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   wdg_keyed #(
      .LEN_W(LEN_W), .UNIT_LOG(UNIT_LOG), .DOMAINS(DOMAINS), .PULSE(PULSE),
      .DEF_LEN(DEF_LEN), .EXT_OUT_REG(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst), .irq(irq),
      .ext_rst(ext_rst), .dom_rst(dom_rst)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired R1-run actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v, exp_v;
      rst_n = 1'b0; tick = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      rd(8'h00, v); chk("R1 mode", v, 32'h0);
      rd(8'h04, v); chk("R1 len", v, 32'(DEF_LEN) << 5);
      rd(8'h18, v); chk("R1 dom reg", v, 32'h0);
      rd(8'h0C, v); chk("R1 count", v, 32'(DEF_LEN) << UNIT_LOG);
      chk("R1 sys_rst", 32'(sys_rst), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 ext_rst", 32'(ext_rst), 1);
      chk("R1 dom_rst", 32'(dom_rst), 0);

      // R2 mode key sweep over every top byte; low byte 0xFE stores 0x5E
      exp_v = 32'h0;
      for (int b = 0; b < 256; b++) begin
         wr(8'h00, {8'(b), 24'h0000FE});
         if (b == 8'h22) exp_v = 32'h5E;
         rd(8'h00, v); chk("R2 mode key", v, exp_v);
      end
      wr(8'h00, 32'h2200_0000);
      rd(8'h00, v); chk("R2 mode clear", v, 32'h0);

      // R3 length key sweep over bits 4:0
      exp_v = 32'(DEF_LEN) << 5;
      for (int k = 0; k < 32; k++) begin
         wr(8'h04, 32'hABCD_0000 | (32'd7 << 5) | 32'(k));
         if (k == 8) exp_v = 32'd7 << 5;
         rd(8'h04, v); chk("R3 len key", v, exp_v);
      end
      step(1);
      rd(8'h0C, v); chk("R5 disabled count tracks reload", v, 32'd7 << UNIT_LOG);

      // R6 R7 R8 expiry sweep over lengths and pin/irq options
      for (int u = 3; u <= 6; u++) begin
         for (int f = 0; f < 8; f++) begin
            int L;
            logic pol, xen, ien;
            L = u << UNIT_LOG;
            pol = f[0]; xen = f[1]; ien = f[2];
            wr(8'h00, 32'h2200_0000 | (32'(f) << 1));
            wr(8'h04, (32'(u) << 5) | 32'h8);
            wr(8'h00, 32'h2200_0001 | (32'(f) << 1));
            rd(8'h0C, v); chk("R5 armed count", v, 32'(L));
            step(L - 1);
            chk("R6 no early expiry", 32'(sys_rst), 0);
            chk("R8 idle pin", 32'(ext_rst), 32'(!pol));
            step(1);
            chk("R6 expiry edge", 32'(sys_rst), 1);
            chk("R7 irq at expiry", 32'(irq), 32'(ien));
            chk("R8 active pin", 32'(ext_rst), xen ? 32'(pol) : 32'(!pol));
            wr(8'h00, 32'h2200_0000 | (32'(f) << 1));
            step(PULSE - 2);
            chk("R6 pulse still high", 32'(sys_rst), 1);
            chk("R7 irq still tracks", 32'(irq), 32'(ien));
            step(1);
            chk("R6 pulse ended", 32'(sys_rst), 0);
            chk("R7 irq ended", 32'(irq), 0);
            chk("R8 pin back idle", 32'(ext_rst), 32'(!pol));
         end
      end

      // R5 tick low freezes the count
      wr(8'h00, 32'h2200_0000);
      wr(8'h04, (32'd3 << 5) | 32'h8);
      tick = 1'b0;
      wr(8'h00, 32'h2200_0001);
      step(10);
      rd(8'h0C, v); chk("R5 frozen without tick", v, 32'd24);
      tick = 1'b1;
      step(5);
      rd(8'h0C, v); chk("R5 decrements per tick", v, 32'd19);
      wr(8'h00, 32'h2200_0000);
      step(2);

      // R11 stop mid-count
      wr(8'h00, 32'h2200_0001);
      step(10);
      wr(8'h00, 32'h2200_0000);
      step(1);
      rd(8'h0C, v); chk("R11 count back at reload", v, 32'd24);
      begin
         logic seen;
         seen = 1'b0;
         for (int i = 0; i < 40; i++) begin
            step(1);
            if (sys_rst) seen = 1'b1;
         end
         chk("R11 no expiry after stop", 32'(seen), 0);
      end

      // R4 kick words
      wr(8'h04, (32'd4 << 5) | 32'h8);
      wr(8'h00, 32'h2200_0001);
      step(20);
      wr(8'h08, 32'h0000_1970);
      rd(8'h0C, v); chk("R4 wrong kick ignored", v, 32'd11);
      wr(8'h08, 32'h0000_1971);
      rd(8'h0C, v); chk("R4 kick reloads", v, 32'd32);
      step(31);
      chk("R4 no expiry before reload runs out", 32'(sys_rst), 0);
      step(1);
      chk("R4 expiry after reload", 32'(sys_rst), 1);
      wr(8'h00, 32'h2200_0000);
      step(20);

      // R9 immediate software reset, disabled timer, irq enabled
      wr(8'h00, 32'h2200_0008);
      wr(8'h14, 32'h0000_1208);
      chk("R9 wrong word ignored", 32'(sys_rst), 0);
      step(1);
      wr(8'h14, 32'h0000_1209);
      chk("R9 reset raised", 32'(sys_rst), 1);
      chk("R9 no irq", 32'(irq), 0);
      step(PULSE - 1);
      chk("R9 pulse still high", 32'(sys_rst), 1);
      step(1);
      chk("R9 pulse ended", 32'(sys_rst), 0);

      // R10 domain key sweep
      exp_v = 32'h0;
      for (int b = 0; b < 256; b++) begin
         logic [3:0] lo;
         lo = 4'(b) ^ 4'h5;
         wr(8'h18, {8'(b), 20'h0, lo});
         if (b == 8'h88) exp_v = 32'(lo);
         chk("R10 dom lines", 32'(dom_rst), exp_v);
         rd(8'h18, v); chk("R10 dom readback", v, exp_v);
      end
      wr(8'h18, 32'h8800_000F);
      chk("R10 all set", 32'(dom_rst), 32'hF);
      wr(8'h18, 32'h8800_0000);
      chk("R10 all clear", 32'(dom_rst), 32'h0);

      finish_run();
   end
endmodule